// File: doc/BRIEF.md
# Two-Wire Slave Bus Front End

This block is the bit-level front end of a two-wire serial slave. It runs on a fast system clock. SCL and SDA are sampled asynchronously, and each line passes through a synchroniser and a stable-count filter that removes short noise pulses. Start and stop conditions are then detected and the bus is tracked bit by bit. The block receives bytes MSB first. It answers its device address with an acknowledge, and it sends read data through an open-drain pull-down output.

The device address is a fixed type nibble of binary 1010, then three strap bits, then the direction bit. A transaction sequencer sits beside the block. It supplies the byte to transmit and reports, through `busy_i`, whether an internal write cycle is still running. While that input is high the address byte is not acknowledged, so the master can poll until the cycle completes. The block reports start, stop, each received data byte, each transmit-byte load, and the master's acknowledge or not-acknowledge after each read byte.

Top module: `twi_slave_front`

## Requirements
- R1: SDA falling while SCL is high raises `start_o` for one cycle. At any point in a transfer this aborts the transfer, and the next eight bits are taken as a fresh address byte.
- R2: SDA rising while SCL is high raises `stop_o` for one cycle. It returns the block to idle with `sda_low_o` released.
- R3: The address byte is bits [7:4] = 1010, bits [3:1] = `strap_i[2:0]` and bit 0 = direction (1 read, 0 write), sent MSB first. On any mismatch the byte gets no acknowledge, and no later byte is acknowledged or reported until the next start.
- R4: While `busy_i` is high on the SCL rise of the eighth address bit, the address is not acknowledged.
- R5: An acknowledge holds `sda_low_o` high from the SCL fall that ends the eighth bit until the SCL fall that ends the ninth bit. The block acknowledges a matched address and, in a write, every data byte.
- R6: In a write, each data byte appears on `rx_byte_o` MSB first, with a one-cycle `rx_valid_o` pulse after its eighth bit.
- R7: In a read, `tx_byte_i` is captured on the SCL fall that ends the acknowledge bit, with a one-cycle `tx_load_o` pulse. The byte is sent MSB first, and `sda_low_o` is high exactly for the zero bits.
- R8: After each read byte, SDA low on the ninth clock gives `mack_o` and continues with the next byte. SDA high gives `mnack_o`, releases the bus and goes to idle.
- R9: A pulse on SCL or SDA shorter than `FILT_CYC` system clocks is ignored.
- R10: `sda_low_o` never changes while SCL is high, except in response to a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock from the bus |
| sda_i | input | 1 | Raw serial data level seen on the bus |
| strap_i | input | 3 | Device address straps (tie low when unused) |
| busy_i | input | 1 | Internal write cycle running; withholds address acknowledge |
| tx_byte_i | input | 8 | Next byte to send in a read |
| sda_low_o | output | 1 | Open-drain control: 1 pulls SDA low, 0 releases it |
| start_o | output | 1 | Start condition pulse |
| stop_o | output | 1 | Stop condition pulse |
| rx_byte_o | output | 8 | Last received write data byte |
| rx_valid_o | output | 1 | Pulse: `rx_byte_o` holds a new byte |
| tx_load_o | output | 1 | Pulse: `tx_byte_i` was captured |
| mack_o | output | 1 | Pulse: master acknowledged a read byte |
| mnack_o | output | 1 | Pulse: master declined a further read byte |

## Verification
Some properties are checked on every cycle by the assertions. The pull-down changes only after an SCL fall or a bus condition. A start leaves the engine at bit zero of a fresh address with the line released. A stop or a master not-acknowledge leaves it idle. An address acknowledge never follows a busy sample. The filter output never flips to a value that was not held for several cycles. Other behaviour can only be shown by the bench's scenarios. These include the exact acknowledge window on the wire, address rejection by strap or by type nibble, and a mid-byte abort followed by a read. They also include the serial values of written and read bytes and the rejection of glitches on either line.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WR,
    ST_ACK_SET,
    ST_ACK_HOLD,
    ST_RD,
    ST_MACK
  } twi_st_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // address byte layout: [7:4] type nibble, [3:1] straps, [0] direction
  function automatic logic addr_hit(input logic [7:0] b, input logic [2:0] strap);
    return (b[7:4] == DEV_TYPE) && (b[3:1] == strap);
  endfunction

  function automatic logic [7:0] shift_in(input logic [7:0] b, input logic bit_in);
    return {b[6:0], bit_in};
  endfunction

endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
  parameter int FILT_CYC    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   s_w;

  assign s_w = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clean_o <= 1'b1;
      run_q   <= '0;
    end else if (s_w != clean_o) begin
      if (run_q == CW'(FILT_CYC - 1)) begin
        clean_o <= s_w;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  // R9: a new filtered level was already present on the synchronised input before
  assert_filter_settled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clean_o) |-> ($past(s_w, 1) == clean_o) && ($past(s_w, 2) == clean_o))
    else $error("filter flipped without a settled input");

endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_c,
  input  logic sda_c,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_c;
      sda_q <= sda_c;
    end
  end

  assign scl_rise = scl_c & ~scl_q;
  assign scl_fall = ~scl_c & scl_q;
  assign start_ev = scl_c & scl_q & sda_q & ~sda_c;
  assign stop_ev  = scl_c & scl_q & ~sda_q & sda_c;

endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
  import twi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       sda_c,
  input  logic [2:0] strap_i,
  input  logic       busy_i,
  input  logic [7:0] tx_byte_i,
  output logic       sda_low_o,
  output logic [7:0] rx_byte_o,
  output logic       rx_valid_o,
  output logic       tx_load_o,
  output logic       mack_o,
  output logic       mnack_o
);
  twi_st_e    st;
  logic [2:0] cnt;
  logic [7:0] sh, txsh, nxt;
  logic       rw, drv;

  assign nxt       = shift_in(sh, sda_c);
  assign sda_low_o = drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; txsh <= '0; rw <= 1'b0; drv <= 1'b0;
      rx_byte_o <= '0; rx_valid_o <= 1'b0; tx_load_o <= 1'b0;
      mack_o <= 1'b0; mnack_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      tx_load_o  <= 1'b0;
      mack_o     <= 1'b0;
      mnack_o    <= 1'b0;
      if (start_ev) begin
        st <= ST_ADDR; cnt <= '0; drv <= 1'b0;
      end else if (stop_ev) begin
        st <= ST_IDLE; drv <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_WR: if (scl_rise) begin
            sh <= nxt;
            if (cnt == 3'd7) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (addr_hit(nxt, strap_i) && !busy_i) begin
                  rw <= nxt[0];
                  st <= ST_ACK_SET;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                rx_byte_o  <= nxt;
                rx_valid_o <= 1'b1;
                st         <= ST_ACK_SET;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ACK_SET: if (scl_fall) begin
            drv <= 1'b1;
            st  <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              txsh      <= tx_byte_i;
              drv       <= ~tx_byte_i[7];
              tx_load_o <= 1'b1;
              st        <= ST_RD;
            end else begin
              drv <= 1'b0;
              st  <= ST_WR;
            end
          end
          ST_RD: if (scl_fall) begin
            if (cnt == 3'd7) begin
              drv <= 1'b0;
              st  <= ST_MACK;
            end else begin
              txsh <= {txsh[6:0], 1'b0};
              drv  <= ~txsh[6];
              cnt  <= cnt + 1'b1;
            end
          end
          ST_MACK: if (scl_rise) begin
            if (!sda_c) begin
              mack_o <= 1'b1;
              st     <= ST_ACK_HOLD;
            end else begin
              mnack_o <= 1'b1;
              st      <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: the pull-down moves only after a filtered SCL fall or a bus condition
  assert_drive_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv) |-> $past(scl_fall || start_ev || stop_ev))
    else $error("SDA drive changed outside SCL low");

  // R1: a start leaves a fresh address reception with the line released
  assert_start_resync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st == ST_ADDR) && (cnt == 3'd0) && !drv)
    else $error("start did not resynchronise");

  // R2: a stop returns to idle with the line released
  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (st == ST_IDLE) && !drv)
    else $error("stop did not idle");

  // R4: no address acknowledge is scheduled after a busy sample
  assert_busy_no_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACK_SET) && ($past(st) == ST_ADDR) |-> !$past(busy_i))
    else $error("address accepted while busy");

  // R6: a received byte is reported right after an SCL rise
  assert_rx_after_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $past(scl_rise))
    else $error("rx pulse without SCL rise");

  // R8: a master decline leaves the engine idle and released
  assert_nack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mnack_o |-> (st == ST_IDLE) && !drv)
    else $error("master nack did not release");

endmodule

// File: rtl/twi_slave_front.sv
module twi_slave_front #(
  parameter int FILT_CYC    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       busy_i,
  input  logic [7:0] tx_byte_i,
  output logic       sda_low_o,
  output logic       start_o,
  output logic       stop_o,
  output logic [7:0] rx_byte_o,
  output logic       rx_valid_o,
  output logic       tx_load_o,
  output logic       mack_o,
  output logic       mnack_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_w, clean_w;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign raw_w = {sda_i, scl_i};

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    twi_glitch_filter #(.FILT_CYC(FILT_CYC), .SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_w[i]), .clean_o(clean_w[i]));
  end

  twi_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_c(clean_w[0]), .sda_c(clean_w[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev));

  twi_byte_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_c(clean_w[1]),
    .strap_i(strap_i), .busy_i(busy_i), .tx_byte_i(tx_byte_i),
    .sda_low_o(sda_low_o), .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o),
    .tx_load_o(tx_load_o), .mack_o(mack_o), .mnack_o(mnack_o));

  assign start_o = start_ev;
  assign stop_o  = stop_ev;

endmodule

// File: tb/tb_twi_slave_front.sv
module tb_twi_slave_front;
  localparam int HALF = 32;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic [2:0] strap = STRAP;
  logic [7:0] tx_byte = 8'h00;
  logic sda_low, start_p, stop_p, rx_valid, tx_load, mack, mnack;
  logic [7:0] rx_byte;
  wire sda_bus = sda_m & ~sda_low;

  always #4 clk = ~clk;

  twi_slave_front dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(strap),
    .busy_i(busy), .tx_byte_i(tx_byte), .sda_low_o(sda_low), .start_o(start_p),
    .stop_o(stop_p), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .tx_load_o(tx_load),
    .mack_o(mack), .mnack_o(mnack));

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;
  int n_start = 0, n_stop = 0, n_load = 0, n_mack = 0, n_mnack = 0;
  logic [7:0] rx_q[$];

  // expected pull-down level while SCL is high, from the model
  logic exp_low = 1'b0, chk_en = 1'b0;
  string chk_req = "R5";
  logic prev_low = 1'b0;

  always @(posedge clk) if (rst_n) begin
    if (start_p)  n_start++;
    if (stop_p)   n_stop++;
    if (tx_load)  n_load++;
    if (mack)     n_mack++;
    if (mnack)    n_mnack++;
    if (rx_valid) rx_q.push_back(rx_byte);
  end

  // per-clock comparison against the model and SCL-high stability (R10)
  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      mon_checks++;
      if (sda_low !== exp_low) begin
        mon_errors++;
        $display("FAIL %s: sda_low act=%0b exp=%0b at %0t", chk_req, sda_low, exp_low, $time);
      end
    end
    if (rst_n && scl_m) begin
      mon_checks++;
      if (sda_low !== prev_low) begin
        mon_errors++;
        $display("FAIL R10: sda_low changed during SCL high act=%0b exp=%0b", sda_low, prev_low);
      end
    end
    prev_low = sda_low;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp_v);
    end
  endtask

  task automatic wait_c(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_start();
    wait_c(4); sda_m = 1'b1; wait_c(HALF);
    scl_m = 1'b1; wait_c(HALF);
    sda_m = 1'b0; wait_c(HALF);
    scl_m = 1'b0; wait_c(4);
  endtask

  task automatic t_stop();
    wait_c(4); sda_m = 1'b0; wait_c(HALF);
    scl_m = 1'b1; wait_c(HALF);
    sda_m = 1'b1; wait_c(HALF);
  endtask

  task automatic clk_bit(input logic b, input logic el, input string req, output logic seen);
    wait_c(4); sda_m = b; wait_c(HALF - 4);
    scl_m = 1'b1; exp_low = el; chk_req = req; chk_en = 1'b1;
    wait_c(HALF / 2); seen = sda_bus;
    wait_c(HALF / 2); chk_en = 1'b0; scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, req, s);
    clk_bit(1'b1, exp_ack, req, s);
    chk(s == !exp_ack, req, int'(!s), int'(exp_ack));
  endtask

  task automatic read_byte(input logic [7:0] exp_b, input logic m_ack, input logic [7:0] next_tx);
    logic s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, !exp_b[i], "R7", s);
      got[i] = s;
    end
    tx_byte = next_tx;
    clk_bit(!m_ack, 1'b0, "R8", s);
    chk(got == exp_b, "R7", got, exp_b);
  endtask

  function automatic logic [7:0] addr_b(input logic [3:0] ty, input logic [2:0] st, input logic rd);
    return {ty, st, rd};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("  Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks + 1);
    $finish;
  end

  initial begin : main
    int ns, np, nrx, nl;
    logic s;
    wait_c(5);
    chk(sda_low == 1'b0, "R2", sda_low, 0);
    chk(start_p == 1'b0 && rx_valid == 1'b0, "R1", start_p, 0);
    rst_n = 1'b1;
    wait_c(20);
    chk(n_start == 0 && sda_low == 1'b0, "R2", n_start, 0);

    // write of two bytes (R3, R5, R6)
    t_start();
    send_byte(addr_b(4'hA, STRAP, 1'b0), 1'b1, "R5");
    send_byte(8'hA5, 1'b1, "R6");
    send_byte(8'h3C, 1'b1, "R6");
    t_stop();
    chk(n_start == 1, "R1", n_start, 1);
    chk(n_stop == 1, "R2", n_stop, 1);
    chk(rx_q.size() == 2, "R6", rx_q.size(), 2);
    if (rx_q.size() == 2) begin
      chk(rx_q[0] == 8'hA5, "R6", rx_q[0], 8'hA5);
      chk(rx_q[1] == 8'h3C, "R6", rx_q[1], 8'h3C);
    end

    // read of two bytes, master ack then nack (R7, R8)
    tx_byte = 8'h96;
    t_start();
    send_byte(addr_b(4'hA, STRAP, 1'b1), 1'b1, "R5");
    read_byte(8'h96, 1'b1, 8'h41);
    read_byte(8'h41, 1'b0, 8'h00);
    t_stop();
    chk(n_mack == 1, "R8", n_mack, 1);
    chk(n_mnack == 1, "R8", n_mnack, 1);
    chk(n_load == 2, "R7", n_load, 2);

    // wrong straps and wrong type nibble: nothing acknowledged or reported (R3)
    nrx = rx_q.size();
    t_start();
    send_byte(addr_b(4'hA, 3'b100, 1'b0), 1'b0, "R3");
    send_byte(8'hFF, 1'b0, "R3");
    t_stop();
    t_start();
    send_byte(addr_b(4'hB, STRAP, 1'b0), 1'b0, "R3");
    send_byte(8'h12, 1'b0, "R3");
    t_stop();
    chk(rx_q.size() == nrx, "R3", rx_q.size(), nrx);

    // busy polling (R4)
    busy = 1'b1;
    t_start();
    send_byte(addr_b(4'hA, STRAP, 1'b0), 1'b0, "R4");
    t_stop();
    busy = 1'b0;
    t_start();
    send_byte(addr_b(4'hA, STRAP, 1'b0), 1'b1, "R4");
    t_stop();

    // start in the middle of a data byte, then a read (R1)
    nrx = rx_q.size(); ns = n_start; nl = n_load;
    t_start();
    send_byte(addr_b(4'hA, STRAP, 1'b0), 1'b1, "R1");
    clk_bit(1'b1, 1'b0, "R1", s);
    clk_bit(1'b0, 1'b0, "R1", s);
    clk_bit(1'b1, 1'b1 & 1'b0, "R1", s);
    clk_bit(1'b1, 1'b0, "R1", s);
    tx_byte = 8'hC3;
    t_start();
    send_byte(addr_b(4'hA, STRAP, 1'b1), 1'b1, "R1");
    read_byte(8'hC3, 1'b0, 8'h00);
    t_stop();
    chk(n_start == ns + 2, "R1", n_start, ns + 2);
    chk(rx_q.size() == nrx, "R1", rx_q.size(), nrx);
    chk(n_load == nl + 1, "R7", n_load, nl + 1);

    // glitches on SDA while idle and on SCL during a write (R9)
    ns = n_start; np = n_stop;
    sda_m = 1'b0; wait_c(3); sda_m = 1'b1; wait_c(30);
    chk(n_start == ns, "R9", n_start, ns);
    chk(n_stop == np, "R9", n_stop, np);
    nrx = rx_q.size();
    t_start();
    send_byte(addr_b(4'hA, STRAP, 1'b0), 1'b1, "R9");
    wait_c(12); scl_m = 1'b1; wait_c(3); scl_m = 1'b0; wait_c(12);
    send_byte(8'h5A, 1'b1, "R9");
    t_stop();
    chk(rx_q.size() == nrx + 1, "R9", rx_q.size(), nrx + 1);
    if (rx_q.size() == nrx + 1) chk(rx_q[nrx] == 8'h5A, "R9", rx_q[nrx], 8'h5A);
    chk(sda_low == 1'b0, "R2", sda_low, 0);

    $display("  Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
    $finish;
  end

endmodule